// File: doc/BRIEF.md
# Set/clear aliased enable register bank

A small bank of interrupt enable and priority registers that sits on a simple write/read bus. A register can be reached through up to two addresses. When it has both a set alias and a clear alias, a write through the set alias turns bits on and a write through the clear alias turns bits off. When it has only one address, a write replaces the stored value. Before decoding, both the bus address and the configured addresses are cut down to their low 29 bits.

Each register is divided into equal fields. A field is one bit for an enable or mask register, or several bits for a priority register. Each field belongs to one interrupt source, and the source number is the register's base number plus the field index. After a write, the bank compares every field of the old value with the same field of the new value. For each field that differs it issues one change event. The event carries the source number and says whether the source is now on or off. Events leave the bank one per clock, lowest field index first. While events are still pending, the bus is held off.

Top module: `alias_enable_bank`

## Requirements
- R1: Matching uses only the low 29 bits of the bus address (address AND 0x1FFFFFFF), compared against the configured addresses reduced the same way. An address that differs from a configured one only in bits 31..29 selects that register.
- R2: For a register with both a set and a clear address, a write through the set address stores old OR data.
- R3: For a register with both a set and a clear address, a write through the clear address stores old AND NOT data.
- R4: For a register with only a set address, or only a clear address, a write stores the data unchanged.
- R5: A register with field width FW holds REG_W/FW fields. Field k occupies bits starting at (REG_W/FW-1-k)*FW, so field 0 is the most significant field. Field k belongs to source base+k. With field width 1, there is one source per bit.
- R6: A write produces an event only for the fields whose old and new contents differ. evt_on is 1 when the new field contents are nonzero, and 0 otherwise. A write that changes no field produces no event.
- R7: A write is accepted in the clock where bus_wr is 1 and bus_ready is 1. Its events appear on the following clocks, one per clock, with field indices ascending. bus_ready is 0 while any event of that write remains. A write presented while bus_ready is 0 changes no register and produces no event.
- R8: bus_rdata shows the stored value of the register that bus_addr selects, through either of its aliases. An address that matches no register reads 0, and a write to it changes nothing and produces no event.
- R9: After reset, every register reads 0, evt_valid is 0 and bus_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write request |
| bus_addr | input | 32 | Address for reads and writes |
| bus_wdata | input | REG_W | Write data |
| bus_ready | output | 1 | 1 when a write can be accepted |
| bus_rdata | output | REG_W | Stored value of the addressed register, 0 when no register matches |
| evt_valid | output | 1 | A change event is presented this cycle |
| evt_src | output | SRC_W | Source number of the event |
| evt_on | output | 1 | 1 = source now enabled, 0 = disabled |

## Verification
The bench drives an address with its top three bits set and checks that it still reaches the set alias. A decoder that compared all 32 bits would leave that register untouched and raise no events. A priority register is written so that one multi-bit field changes from nonzero to zero while another changes from zero to nonzero. This catches a bank that reverses the field order, uses the wrong field offsets, or bases the on/off flag on a single bit. The bench also rewrites a value that is already stored, and it writes during a burst of events. In each case any stray event, or a register that changes, shows up against the reference queue. A bank that got the set and clear aliases backwards, or that merged data into a register with a single address, would show the wrong value on the read port.

// File: rtl/alias_bank_pkg.sv
package alias_bank_pkg;

  typedef enum logic [1:0] {
    WM_NONE  = 2'd0,
    WM_SET   = 2'd1,
    WM_CLR   = 2'd2,
    WM_PLAIN = 2'd3
  } wr_mode_e;

  localparam logic [31:0] ADDR_KEEP = 32'h1FFF_FFFF;

  function automatic logic [31:0] reduce_addr(input logic [31:0] a);
    return a & ADDR_KEEP;
  endfunction

  function automatic logic [31:0] merge_value(input wr_mode_e m,
                                              input logic [31:0] old_v,
                                              input logic [31:0] d);
    case (m)
      WM_SET:   return old_v | d;
      WM_CLR:   return old_v & ~d;
      WM_PLAIN: return d;
      default:  return old_v;
    endcase
  endfunction

  // contents of field k when a register has nf fields of fw bits each
  function automatic logic [31:0] field_get(input logic [31:0] v, input int k,
                                            input int fw, input int nf);
    int          sh;
    logic [31:0] msk;
    sh  = (nf - 1 - k) * fw;
    msk = (fw >= 32) ? 32'hFFFF_FFFF : ((32'h1 << fw) - 32'h1);
    return (v >> sh) & msk;
  endfunction

endpackage

// File: rtl/alias_decoder.sv
module alias_decoder
  import alias_bank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W = 2,
  parameter logic [NUM_REGS*32-1:0] SET_ADDRS = '0,
  parameter logic [NUM_REGS*32-1:0] CLR_ADDRS = '0
) (
  input  logic [31:0]      addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output wr_mode_e         mode
);
  logic [31:0] ra;
  assign ra = reduce_addr(addr);

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    mode = WM_NONE;
    // walk downward so that the lowest matching register wins
    for (int r = NUM_REGS - 1; r >= 0; r--) begin
      logic [31:0] sa, ca;
      logic        sm, cm;
      sa = SET_ADDRS[r*32 +: 32];
      ca = CLR_ADDRS[r*32 +: 32];
      sm = (sa != 32'h0) && (ra == reduce_addr(sa));
      cm = (ca != 32'h0) && (ra == reduce_addr(ca));
      if (sm || cm) begin
        hit = 1'b1;
        idx = IDX_W'(r);
        if (sa != 32'h0 && ca != 32'h0) mode = sm ? WM_SET : WM_CLR;
        else                            mode = WM_PLAIN;
      end
    end
  end
endmodule

// File: rtl/field_diff.sv
module field_diff
  import alias_bank_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int NUM_REGS = 4,
  parameter int IDX_W = 2,
  parameter logic [NUM_REGS*8-1:0] FIELD_WS = '0
) (
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [REG_W-1:0] old_v,
  input  logic [REG_W-1:0] new_v,
  output logic [REG_W-1:0] changed
);
  logic [31:0] old_w, new_w;
  int          fw, nf;

  assign old_w = 32'(old_v);
  assign new_w = 32'(new_v);

  always_comb begin
    fw = int'(FIELD_WS[int'(reg_idx)*8 +: 8]);
    if (fw == 0) fw = 1;
    nf = REG_W / fw;
    for (int k = 0; k < REG_W; k++)
      changed[k] = (k < nf) &&
                   (field_get(old_w, k, fw, nf) != field_get(new_w, k, fw, nf));
  end
endmodule

// File: rtl/event_sequencer.sv
module event_sequencer #(
  parameter int REG_W = 16,
  parameter int IDX_W = 2,
  parameter int FI_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] load_mask,
  input  logic [IDX_W-1:0] load_reg,
  output logic             pending_any,
  output logic [FI_W-1:0]  cur_field,
  output logic [IDX_W-1:0] cur_reg
);
  logic [REG_W-1:0] pending;

  assign pending_any = |pending;

  always_comb begin
    cur_field = '0;
    for (int k = REG_W - 1; k >= 0; k--)
      if (pending[k]) cur_field = FI_W'(k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      cur_reg <= '0;
    end else if (load && !pending_any) begin
      pending <= load_mask;
      cur_reg <= load_reg;
    end else if (pending_any) begin
      pending[cur_field] <= 1'b0;
    end
  end

  // R7: each clock with a pending event retires exactly one field
  assert_one_per_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending_any |=> ($countones(pending) == $countones($past(pending)) - 1));

  // R7: within one burst the field index climbs
  assert_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_any && !$rose(pending_any)) |-> (cur_field > $past(cur_field)));
endmodule

// File: rtl/alias_enable_bank.sv
module alias_enable_bank
  import alias_bank_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int NUM_REGS = 4,
  parameter int SRC_W = 8,
  parameter logic [NUM_REGS*32-1:0] SET_ADDRS =
    {32'h0000_00C0, 32'h0000_0000, 32'h0000_0080, 32'h0000_0040},
  parameter logic [NUM_REGS*32-1:0] CLR_ADDRS =
    {32'h0000_0000, 32'h0000_00A0, 32'h0000_0000, 32'h0000_0060},
  parameter logic [NUM_REGS*8-1:0] FIELD_WS = {8'd4, 8'd1, 8'd1, 8'd1},
  parameter logic [NUM_REGS*8-1:0] SRC_BASES = {8'd48, 8'd32, 8'd16, 8'd0}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [31:0]      bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic             bus_ready,
  output logic [REG_W-1:0] bus_rdata,
  output logic             evt_valid,
  output logic [SRC_W-1:0] evt_src,
  output logic             evt_on
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int FI_W  = (REG_W > 1) ? $clog2(REG_W) : 1;

  logic [REG_W-1:0]          regs [NUM_REGS];
  logic [NUM_REGS*REG_W-1:0] reg_flat;
  logic                      hit, accept, busy, load;
  logic [IDX_W-1:0]          idx, cur_reg;
  wr_mode_e                  mode;
  logic [REG_W-1:0]          old_v, new_v, changed;
  logic [31:0]               merged, cur_w, cur_fld;
  logic [FI_W-1:0]           cur_field;
  int                        cur_fw, cur_nf;

  alias_decoder #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W),
                  .SET_ADDRS(SET_ADDRS), .CLR_ADDRS(CLR_ADDRS))
    u_dec (.addr(bus_addr), .hit(hit), .idx(idx), .mode(mode));

  assign old_v  = regs[idx];
  assign merged = merge_value(mode, 32'(old_v), 32'(bus_wdata));
  assign new_v  = merged[REG_W-1:0];

  field_diff #(.REG_W(REG_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .FIELD_WS(FIELD_WS))
    u_diff (.reg_idx(idx), .old_v(old_v), .new_v(new_v), .changed(changed));

  assign accept = bus_wr && !busy && hit;
  assign load   = accept && (|changed);

  event_sequencer #(.REG_W(REG_W), .IDX_W(IDX_W), .FI_W(FI_W))
    u_seq (.clk(clk), .rst_n(rst_n), .load(load), .load_mask(changed),
           .load_reg(idx), .pending_any(busy), .cur_field(cur_field),
           .cur_reg(cur_reg));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           regs[r] <= '0;
      else if (accept && idx == IDX_W'(r))  regs[r] <= new_v;
    end
    assign reg_flat[r*REG_W +: REG_W] = regs[r];
  end

  assign bus_ready = !busy;
  assign bus_rdata = hit ? regs[idx] : '0;

  always_comb begin
    cur_fw = int'(FIELD_WS[int'(cur_reg)*8 +: 8]);
    if (cur_fw == 0) cur_fw = 1;
    cur_nf = REG_W / cur_fw;
  end
  assign cur_w     = 32'(regs[cur_reg]);
  assign cur_fld   = field_get(cur_w, int'(cur_field), cur_fw, cur_nf);
  assign evt_valid = busy;
  assign evt_on    = (cur_fld != 32'h0);
  assign evt_src   = SRC_W'(SRC_BASES[int'(cur_reg)*8 +: 8]) + SRC_W'(cur_field);

  // R2: a set-alias write leaves every written 1-bit set
  assert_set_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == WM_SET) |=>
      ((regs[$past(idx)] & $past(bus_wdata)) == $past(bus_wdata)));

  // R3: a clear-alias write leaves every written 1-bit cleared
  assert_clr_andnot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == WM_CLR) |=> ((regs[$past(idx)] & $past(bus_wdata)) == '0));

  // R6: a write that changes no field raises no event
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && changed == '0) |=> !evt_valid);

  // R7: registers hold while events drain
  assert_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(reg_flat));

  // R8: a write to an unmapped address leaves the bank alone
  assert_miss_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit) |=> $stable(reg_flat));
endmodule

// File: tb/alias_enable_bank_tb.sv
module alias_enable_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_addr = 32'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic        bus_ready, evt_valid, evt_on;
  logic [15:0] bus_rdata;
  logic [7:0]  evt_src;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int m_set  [4] = '{32'h40, 32'h80, 32'h0, 32'hC0};
  int m_clr  [4] = '{32'h60, 32'h0, 32'hA0, 32'h0};
  int m_fw   [4] = '{1, 1, 1, 4};
  int m_base [4] = '{0, 16, 32, 48};
  int m_val  [4] = '{0, 0, 0, 0};
  int evq [$];

  always #10 clk = ~clk;

  alias_enable_bank u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .evt_valid(evt_valid), .evt_src(evt_src), .evt_on(evt_on));

  function automatic int find_reg(int a);
    int ra = a & 32'h1FFF_FFFF;
    for (int r = 0; r < 4; r++)
      if ((m_set[r] != 0 && ra == m_set[r]) || (m_clr[r] != 0 && ra == m_clr[r]))
        return r;
    return -1;
  endfunction

  function automatic void model_write(int a, int d);
    int r, ra, nv, fw, nf, msk, pos, of, nfv;
    r = find_reg(a);
    if (r < 0) return;
    ra = a & 32'h1FFF_FFFF;
    if (m_set[r] != 0 && m_clr[r] != 0)
      nv = (ra == m_set[r]) ? (m_val[r] | d) : (m_val[r] & ~d);
    else
      nv = d;
    nv = nv & 16'hFFFF;
    fw = m_fw[r];
    nf = 16 / fw;
    msk = (1 << fw) - 1;
    for (int k = 0; k < nf; k++) begin
      pos = 16 - (k + 1) * fw;
      of  = (m_val[r] >> pos) & msk;
      nfv = (nv >> pos) & msk;
      if (of != nfv) evq.push_back((m_base[r] + k) * 2 + ((nfv != 0) ? 1 : 0));
    end
    m_val[r] = nv;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit wr, int a, int d);
    int r, expr;
    @(negedge clk);
    r = find_reg(int'(bus_addr));
    expr = (r < 0) ? 0 : m_val[r];
    chk(tag, "bus_ready", int'(bus_ready), (evq.size() == 0) ? 1 : 0);
    chk(tag, "evt_valid", int'(evt_valid), (evq.size() != 0) ? 1 : 0);
    chk(tag, "bus_rdata", int'(bus_rdata), expr);
    if (evq.size() != 0 && evt_valid) begin
      chk(tag, "evt_src", int'(evt_src), evq[0] / 2);
      chk(tag, "evt_on", int'(evt_on), evq[0] % 2);
    end
    if (evq.size() != 0) void'(evq.pop_front());
    else if (wr) model_write(a, d);
    bus_wr = wr;
    bus_addr = 32'(a);
    bus_wdata = 16'(d);
  endtask

  task automatic wr_drain(string tag, int a, int d);
    step(tag, 1'b1, a, d);
    step(tag, 1'b0, a, 0);
    while (evq.size() != 0) step(tag, 1'b0, a, 0);
    step(tag, 1'b0, a, 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R9: reset state, reads of every alias are zero
    step("R9", 0, 32'h40, 0);
    step("R9", 0, 32'hA0, 0);
    step("R9", 0, 32'hC0, 0);
    // R1 and R2: set alias reached with high address bits set
    step("R1", 1, 32'hE000_0040, 16'h8001);
    // R7: write during the burst is ignored
    step("R7", 1, 32'h80, 16'hFFFF);
    step("R7", 0, 32'h80, 0);
    step("R7", 0, 32'h80, 0);
    // R8: read back through the clear alias
    step("R8", 0, 32'h60, 0);
    wr_drain("R2", 32'h40, 16'h0003);
    wr_drain("R3", 32'h60, 16'h8002);
    // R4: plain set-only and clear-only registers replace
    wr_drain("R4", 32'h80, 16'h00F0);
    wr_drain("R4", 32'h80, 16'h0F00);
    wr_drain("R4", 32'hA0, 16'h1234);
    // R5: multi-bit priority fields, field 0 most significant
    wr_drain("R5", 32'hC0, 16'h1230);
    wr_drain("R5", 32'hC0, 16'h1034);
    // R6: rewriting the stored value raises nothing
    wr_drain("R6", 32'hC0, 16'h1034);
    wr_drain("R6", 32'h40, 16'h0001);
    // R8: unmapped addresses
    wr_drain("R8", 32'h100, 16'hFFFF);
    // R1: bits below 29 still must match
    wr_drain("R1", 32'hFFFF_FFC0, 16'hFFFF);
    step("R5", 0, 32'hC0, 0);
    step("R5", 0, 32'hC0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule